// File: doc/BRIEF.md
# Return Address Predictor Stack

This block predicts where a subroutine return will go. Each call strobe records the address that follows the call instruction, which is the call PC plus a fixed instruction size. The recorded addresses sit in a small circular buffer. A top pointer selects the most recent entry, and `pred_addr_o` always shows that entry. A return strobe consumes the top entry, so the fetch stage reads the prediction in the cycle it raises `ret_i`.

When calls nest deeper than the buffer, the pointer wraps and each new address overwrites the oldest one, so the newest entries stay correct. An occupancy count saturates at the depth and at zero. `pred_valid_o` shows whether the top entry is backed by a recorded call. A return on an empty stack still moves the pointer down and leaves a stale address on the output with the valid flag low. When a call and a return arrive in the same cycle, the return is applied first and the push second, so the new address replaces the top entry.

Top module: `ret_addr_stack`

## Requirements
- R1: While reset is applied and after it is released, the top pointer and the occupancy are zero, so `pred_valid_o` is low.
- R2: A call alone pushes `call_pc_i + INSN_BYTES`, and `pred_addr_o` shows it in the next cycle (a call at 0xFC34 yields 0xFC38).
- R3: A return alone pops the top entry, and `pred_addr_o` then shows the entry recorded before it, in last-in first-out order.
- R4: The occupancy rises by one per call and saturates at DEPTH. `pred_valid_o` is high exactly when the occupancy is non-zero.
- R5: After DEPTH+m calls, the pointer has wrapped. The DEPTH newest addresses come back in reverse order, and the pops after them show addresses that were overwritten.
- R6: A return with zero occupancy leaves the occupancy at zero and `pred_valid_o` low, but the pointer still decrements. `pred_addr_o` then shows the stale slot below.
- R7: A call and a return in the same cycle replace the top entry with the new return address. The occupancy is unchanged, except that it rises from zero to one.
- R8: Repeated calls from one site keep every slot equal to the same return address, so every pop predicts that address even after overflow.
- R9: In a cycle with neither strobe, `pred_addr_o` and `pred_valid_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| call_i | input | 1 | Call strobe: push the return address of `call_pc_i` |
| ret_i | input | 1 | Return strobe: pop the top entry |
| call_pc_i | input | ADDR_W | Address of the call instruction |
| pred_addr_o | output | ADDR_W | Predicted return target (top entry) |
| pred_valid_o | output | 1 | Top entry is backed by a recorded call |

## Verification
The bench builds the default configuration: 4 entries of 32 bits with a 4-byte instruction size. With only four slots, a sweep that makes 0 to 6 calls and then pops two past empty covers every pointer wrap, the overflow by one and by two, and every pop below zero. The expected address and valid flag for each step are derived from the call count and the pop count. Separate runs cover same-cycle call and return (on an empty stack and on a filled one), single-site recursion and idle holding.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Operation applied to the stack in one cycle; bit 1 = return, bit 0 = call.
  typedef enum logic [1:0] {
    RAS_IDLE = 2'b00,
    RAS_PUSH = 2'b01,
    RAS_POP  = 2'b10,
    RAS_SWAP = 2'b11
  } ras_op_e;

  function automatic ras_op_e ras_decode(input logic call, input logic ret);
    return ras_op_e'({ret, call});
  endfunction

endpackage

// File: rtl/ras_rst_sync.sv
module ras_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/ras_ptr_ctl.sv
module ras_ptr_ctl
  import ras_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ras_op_e          op_i,
  output logic [PTR_W-1:0] top_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o
);

  logic [PTR_W-1:0] top_q, top_d;
  logic             top_en;

  // Pop is applied before push; DEPTH is a power of two so the counter wraps.
  always_comb begin
    top_d = top_q;
    unique case (op_i)
      RAS_PUSH: top_d = top_q + PTR_W'(1);
      RAS_POP:  top_d = top_q - PTR_W'(1);
      default:  top_d = top_q;
    endcase
  end

  assign top_en   = (op_i == RAS_PUSH) || (op_i == RAS_POP);
  assign wr_en_o  = (op_i == RAS_PUSH) || (op_i == RAS_SWAP);
  assign wr_idx_o = top_d;
  assign top_o    = top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '0;
    else if (top_en) top_q <= top_d;
  end

endmodule

// File: rtl/ras_fill_cnt.sv
module ras_fill_cnt
  import ras_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ras_op_e op_i,
  output logic    nonempty_o
);

  logic [CNT_W-1:0] occ_q, occ_d;
  logic             occ_en;
  logic             at_full, at_empty;

  assign at_full  = (occ_q == CNT_W'(DEPTH));
  assign at_empty = (occ_q == '0);

  always_comb begin
    occ_d = occ_q;
    unique case (op_i)
      RAS_PUSH: occ_d = at_full  ? occ_q : occ_q + CNT_W'(1);
      RAS_POP:  occ_d = at_empty ? occ_q : occ_q - CNT_W'(1);
      RAS_SWAP: occ_d = at_empty ? CNT_W'(1) : occ_q;
      default:  occ_d = occ_q;
    endcase
  end

  assign occ_en     = (op_i != RAS_IDLE);
  assign nonempty_o = !at_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  // R4
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CNT_W'(DEPTH));

  // R4
  fill_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_PUSH && at_full) |=> (occ_q == CNT_W'(DEPTH)));

  // R6
  fill_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_POP && at_empty) |=> (occ_q == '0));

endmodule

// File: rtl/ras_slot_file.sv
module ras_slot_file #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);

  logic [DEPTH-1:0][ADDR_W-1:0] slot_vec;

  // Data slots carry no reset; validity is tracked by the fill counter.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ADDR_W-1:0] entry_q;
    logic              entry_we;

    assign entry_we = wr_en_i && (wr_idx_i == PTR_W'(g));

    always_ff @(posedge clk_i) begin
      if (entry_we) entry_q <= wr_data_i;
    end

    assign slot_vec[g] = entry_q;
  end

  assign rd_data_o = slot_vec[rd_idx_i];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  localparam int PTR_W     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] call_pc_i,
  output logic [ADDR_W-1:0] pred_addr_o,
  output logic              pred_valid_o
);

  logic              rst_sync_n;
  ras_op_e           op;
  logic [PTR_W-1:0]  top_idx;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] ret_addr;

  ras_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  assign op       = ras_decode(call_i, ret_i);
  assign ret_addr = call_pc_i + ADDR_W'(INSN_BYTES);

  ras_ptr_ctl #(.DEPTH(DEPTH)) i_ptr_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .op_i     (op),
    .top_o    (top_idx),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx)
  );

  ras_fill_cnt #(.DEPTH(DEPTH)) i_fill_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .op_i       (op),
    .nonempty_o (pred_valid_o)
  );

  ras_slot_file #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_slot_file (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (ret_addr),
    .rd_idx_i  (top_idx),
    .rd_data_o (pred_addr_o)
  );

  // R1
  reset_empty_chk: assert property (@(posedge clk_i)
    !rst_sync_n |=> !pred_valid_o);

  // R2
  push_target_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (call_i && !ret_i) |=> (pred_addr_o == $past(call_pc_i) + ADDR_W'(INSN_BYTES)) && pred_valid_o);

  // R6
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ret_i && !call_i && !pred_valid_o) |=> !pred_valid_o);

  // R7
  swap_top_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (call_i && ret_i) |=> (pred_addr_o == $past(call_pc_i) + ADDR_W'(INSN_BYTES)) && pred_valid_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!call_i && !ret_i) |=> $stable(pred_addr_o) && $stable(pred_valid_o));

endmodule

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int ADDR_W     = 32;
  localparam int INSN_BYTES = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              call_i = 1'b0;
  logic              ret_i = 1'b0;
  logic [ADDR_W-1:0] call_pc_i = '0;
  logic [ADDR_W-1:0] pred_addr_o;
  logic              pred_valid_o;

  int checks = 0;
  int errors = 0;

  ret_addr_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) i_ret_addr_stack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .call_pc_i    (call_pc_i),
    .pred_addr_o  (pred_addr_o),
    .pred_valid_o (pred_valid_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] site_pc(input int j);
    return 32'h0040_1000 + ADDR_W'(j) * 32'h0000_0124;
  endfunction

  // Drive one cycle of strobes; return at the following falling edge.
  task automatic op(input logic c, input logic r, input logic [ADDR_W-1:0] pc);
    call_i    = c;
    ret_i     = r;
    call_pc_i = pc;
    @(negedge clk_i);
    call_i = 1'b0;
    ret_i  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] held_addr;
    logic              held_valid;

    // R1: reset state, during and after reset
    @(negedge clk_i);
    chk("R1 during reset", ADDR_W'(pred_valid_o), '0);
    do_reset();
    chk("R1 after reset", ADDR_W'(pred_valid_o), '0);

    // R2: worked example
    op(1'b1, 1'b0, 32'h0000_FC34);
    chk("R2 fc34", pred_addr_o, 32'h0000_FC38);
    chk("R2 valid", ADDR_W'(pred_valid_o), 1);

    // Sweep: n calls then n+2 returns, for n = 0..6
    for (int n = 0; n <= 6; n++) begin
      do_reset();
      for (int j = 1; j <= n; j++) begin
        op(1'b1, 1'b0, site_pc(j));
        chk("R2 push", pred_addr_o, site_pc(j) + INSN_BYTES);
        chk("R4 valid after push", ADDR_W'(pred_valid_o), 1);
      end
      for (int k = 1; k <= n + 2; k++) begin
        int  filled;
        int  occ_exp;
        int  idx;
        int  src;
        filled = (n < DEPTH) ? n : DEPTH;
        if (filled == k - 1)
          chk("R6 valid low while popping empty", ADDR_W'(pred_valid_o), 0);
        op(1'b0, 1'b1, '0);
        occ_exp = (filled - k > 0) ? filled - k : 0;
        chk((n > DEPTH) ? "R5 valid after pop" : "R4 valid after pop",
            ADDR_W'(pred_valid_o), ADDR_W'(occ_exp != 0));
        idx = (((n - k) % DEPTH) + DEPTH) % DEPTH;
        src = 0;
        for (int j = n; j >= 1; j--) begin
          if (src == 0 && (j % DEPTH) == idx) src = j;
        end
        if (src != 0) begin
          if (filled - k < 0)      chk("R6 stale slot after empty pop", pred_addr_o, site_pc(src) + INSN_BYTES);
          else if (n > DEPTH)      chk("R5 wrapped order", pred_addr_o, site_pc(src) + INSN_BYTES);
          else                     chk("R3 lifo order", pred_addr_o, site_pc(src) + INSN_BYTES);
        end
      end
    end

    // R8: recursion from one site past the capacity
    do_reset();
    for (int j = 0; j < 7; j++) op(1'b1, 1'b0, 32'h0000_2A00);
    for (int k = 1; k <= 7; k++) begin
      op(1'b0, 1'b1, '0);
      chk("R8 recursion target", pred_addr_o, 32'h0000_2A04);
    end

    // R7: simultaneous call and return on a filled stack
    do_reset();
    op(1'b1, 1'b0, site_pc(1));
    op(1'b1, 1'b0, site_pc(2));
    op(1'b1, 1'b1, site_pc(9));
    chk("R7 swap replaces top", pred_addr_o, site_pc(9) + INSN_BYTES);
    chk("R7 swap valid", ADDR_W'(pred_valid_o), 1);
    op(1'b0, 1'b1, '0);
    chk("R7 entry below kept", pred_addr_o, site_pc(1) + INSN_BYTES);
    chk("R7 depth unchanged", ADDR_W'(pred_valid_o), 1);
    op(1'b0, 1'b1, '0);
    chk("R7 depth unchanged empty", ADDR_W'(pred_valid_o), 0);

    // R7: simultaneous call and return on an empty stack
    do_reset();
    op(1'b1, 1'b1, site_pc(11));
    chk("R7 swap on empty addr", pred_addr_o, site_pc(11) + INSN_BYTES);
    chk("R7 swap on empty valid", ADDR_W'(pred_valid_o), 1);
    op(1'b0, 1'b1, '0);
    chk("R7 swap on empty depth one", ADDR_W'(pred_valid_o), 0);

    // R9: idle cycles hold outputs
    do_reset();
    op(1'b1, 1'b0, site_pc(3));
    op(1'b1, 1'b0, site_pc(4));
    held_addr  = pred_addr_o;
    held_valid = pred_valid_o;
    for (int i = 0; i < 3; i++) begin
      op(1'b0, 1'b0, 32'hDEAD_BEEF);
      chk("R9 idle addr", pred_addr_o, held_addr);
      chk("R9 idle valid", ADDR_W'(pred_valid_o), ADDR_W'(held_valid));
    end
    op(1'b0, 1'b1, '0);
    chk("R9 state intact after idle", pred_addr_o, site_pc(3) + INSN_BYTES);

    finish_run();
  end

endmodule